// File: doc/BRIEF.md
# Burst Tenure Timer

This block limits how long a bus master may go on bursting once it has won the bus. Software programs an 8-bit configuration register whose upper five bits give a tenure budget in steps of eight bus clocks. When the master opens a transaction, it pulses `start` in the cycle in which it first drives its frame signal. The timer then loads the budget and counts down one step per clock for as long as the frame stays asserted.

Once the budget is used up the timer stays at zero. From then on, any clock edge at which the grant is absent raises `term_req`, a registered request for the master to release frame and end the burst. While the grant stays present the master may keep the bus indefinitely. Arbitration, address and data phases and the target side belong to other blocks.

Top module: `burst_tenure_timer`

## Requirements
- R1: After a clock edge with `rst` high, `cfg_rdata` reads 00h and `term_req` is 0.
- R2: A clock edge with `cfg_we` high stores `cfg_wdata[7:3]` as the count field. `cfg_rdata[7:3]` shows the stored field combinationally from then on.
- R3: `cfg_rdata[2:0]` always read 0, and the write data on those bits has no effect on the read value or on the timing.
- R4: With field value N>0, the edge at which `start` is high is edge 0 of the burst. With `frame_on` held high, `term_req` can first be 1 after edge 8N+1, and only if `gnt` was low at that edge. Before that it stays 0.
- R5: `term_req` is 0 after any edge at which `gnt` was high, even after expiry. If the grant is withdrawn after expiry, `term_req` is 1 after the next edge.
- R6: With a field value of 0 the timer is already expired at the start edge, so `gnt` low at edge 1 gives `term_req` 1 after edge 1.
- R7: After expiry the count holds at zero and does not wrap. `term_req` stays 1 on every edge at which `frame_on` is high, `gnt` is low and `start` is low.
- R8: `term_req` is 0 after any edge at which `frame_on` was low. The count pauses while frame is low, and `term_req` stays 0 until the next `start`.
- R9: An edge with `start` high reloads the count from the field and leaves `term_req` at 0.
- R10: A register write during a burst does not change the running count. The new value applies from the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read value, combinational |
| start | input | 1 | One-clock pulse in the cycle frame is first asserted |
| frame_on | input | 1 | Frame currently asserted by the master |
| gnt | input | 1 | Bus grant to this master |
| term_req | output | 1 | Registered request to release frame |

## Verification
The bench goes after the exact expiry edge for several budgets, including the extremes 0, 1 and 31. A design that scaled the field wrongly, or started counting one clock late or early, would raise `term_req` on the wrong edge. It holds the grant well past expiry and then drops it, which catches a design that ignores the grant or forgets the expiry. It also runs long over-budget bursts, where a wrapping counter would drop `term_req`. Finally it writes the register in the middle of a burst and loads it with ones in the reserved bits: a design that reloaded on write, or kept the reserved bits, would show a shifted termination or a nonzero low read value.

// File: rtl/btt_pkg.sv
package btt_pkg;
  // Countdown state as seen by the terminate stage
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_COUNTING = 2'd1,
    ST_EXPIRED  = 2'd2
  } btt_status_t;
endpackage

// File: rtl/btt_cfg_reg.sv
module btt_cfg_reg #(
  parameter int REG_W     = 8,
  parameter int FIELD_LSB = 3,
  localparam int FIELD_W  = REG_W - FIELD_LSB
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   rdata,
  output logic [FIELD_W-1:0] field
);
  logic [FIELD_W-1:0] field_q;

  always_ff @(posedge clk) begin
    if (rst) field_q <= '0;
    else if (we) field_q <= wdata[REG_W-1:FIELD_LSB];
  end

  assign field = field_q;

  // Reserved low bits read as zero; variant chosen by layout
  generate
    if (FIELD_LSB > 0) begin : g_rsv
      assign rdata = {field_q, {FIELD_LSB{1'b0}}};
    end else begin : g_norsv
      assign rdata = field_q;
    end
  endgenerate
endmodule

// File: rtl/btt_countdown.sv
module btt_countdown
  import btt_pkg::*;
#(
  parameter int FIELD_W     = 5,
  parameter int SCALE_SHIFT = 3,
  localparam int CNT_W      = FIELD_W + SCALE_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               frame_on,
  input  logic [FIELD_W-1:0] field,
  output btt_status_t        status
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [CNT_W-1:0] load_val;

  generate
    if (SCALE_SHIFT > 0) begin : g_scale
      assign load_val = {field, {SCALE_SHIFT{1'b0}}};
    end else begin : g_noscale
      assign load_val = field;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= load_val;
      run_q <= 1'b1;
    end else begin
      if (!frame_on) run_q <= 1'b0;
      if (frame_on && (cnt_q != '0)) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    if (!(run_q && frame_on)) status = ST_IDLE;
    else if (cnt_q == '0)     status = ST_EXPIRED;
    else                      status = ST_COUNTING;
  end
endmodule

// File: rtl/btt_term.sv
module btt_term
  import btt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        gnt,
  input  btt_status_t status,
  output logic        term_req
);
  logic term_q;

  always_ff @(posedge clk) begin
    if (rst) term_q <= 1'b0;
    else     term_q <= !start && !gnt && (status == ST_EXPIRED);
  end

  assign term_req = term_q;
endmodule

// File: rtl/burst_tenure_timer.sv
module burst_tenure_timer
  import btt_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int FIELD_LSB   = 3,
  parameter int SCALE_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             start,
  input  logic             frame_on,
  input  logic             gnt,
  output logic             term_req
);
  localparam int FIELD_W = REG_W - FIELD_LSB;

  logic [FIELD_W-1:0] field;
  btt_status_t        status;

  btt_cfg_reg #(.REG_W(REG_W), .FIELD_LSB(FIELD_LSB)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .field(field)
  );

  btt_countdown #(.FIELD_W(FIELD_W), .SCALE_SHIFT(SCALE_SHIFT)) u_cnt (
    .clk(clk), .rst(rst), .start(start), .frame_on(frame_on),
    .field(field), .status(status)
  );

  btt_term u_term (
    .clk(clk), .rst(rst), .start(start), .gnt(gnt),
    .status(status), .term_req(term_req)
  );
endmodule

// File: rtl/btt_checker.sv
module btt_checker #(
  parameter int REG_W     = 8,
  parameter int FIELD_LSB = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [REG_W-1:0] cfg_wdata,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             start,
  input logic             frame_on,
  input logic             gnt,
  input logic             term_req
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!term_req && cfg_rdata == '0));

  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !$past(rst)) |=> cfg_rdata[REG_W-1:FIELD_LSB] == $past(cfg_wdata[REG_W-1:FIELD_LSB]));

  a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[FIELD_LSB-1:0] == '0);

  a_r5_grant_keeps_bus: assert property (@(posedge clk) disable iff (rst)
    gnt |=> !term_req);

  a_r7_hold_expired: assert property (@(posedge clk) disable iff (rst)
    (term_req && frame_on && !gnt && !start) |=> term_req);

  a_r8_no_frame: assert property (@(posedge clk) disable iff (rst)
    !frame_on |=> !term_req);

  a_r9_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> !term_req);
endmodule

bind burst_tenure_timer btt_checker #(.REG_W(REG_W), .FIELD_LSB(FIELD_LSB)) i_btt_checker (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .start(start), .frame_on(frame_on),
  .gnt(gnt), .term_req(term_req)
);

// File: tb/test_burst_tenure_timer.sv
module test_burst_tenure_timer;
  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       start;
  logic       frame_on;
  logic       gnt;
  logic       term_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;  // 250 MHz

  burst_tenure_timer i_burst_tenure_timer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .start(start), .frame_on(frame_on),
    .gnt(gnt), .term_req(term_req)
  );

  function automatic logic [7:0] exp_rdata(input logic [7:0] w);
    return w & 8'hF8;
  endfunction

  // Edge k after the start edge (k>=1), frame held high throughout
  function automatic logic exp_term(input int k, input int n, input logic g);
    return (k >= 8 * n + 1) && !g;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic write_cfg(input logic [7:0] w, input string req);
    cfg_we = 1'b1; cfg_wdata = w;
    tick();
    cfg_we = 1'b0;
    check(req, cfg_rdata, exp_rdata(w));
  endtask

  // mode 0: grant low, 1: grant held past expiry then dropped,
  // 2: random grant, 3: grant always high
  task automatic burst(input int n, input int extra, input int mode, input bit midwrite);
    int len;
    logic [7:0] newval;
    len = 8 * n + 2 + extra;
    write_cfg({n[4:0], 3'($urandom)}, "R2");
    newval = {5'($urandom), 3'b111};
    start = 1'b1; frame_on = 1'b1; gnt = 1'b0;
    tick();
    start = 1'b0;
    check("R9", {7'd0, term_req}, 8'd0);
    for (int k = 1; k <= len; k++) begin
      case (mode)
        0: gnt = 1'b0;
        1: gnt = (k <= 8 * n + 3);
        2: gnt = 1'($urandom);
        default: gnt = 1'b1;
      endcase
      if (midwrite && k == 2) begin cfg_we = 1'b1; cfg_wdata = newval; end
      else cfg_we = 1'b0;
      tick();
      if (n == 0)                                   check("R6", {7'd0, term_req}, {7'd0, exp_term(k, n, gnt)});
      else if (midwrite)                            check("R10", {7'd0, term_req}, {7'd0, exp_term(k, n, gnt)});
      else if (mode == 1 || mode == 3)              check("R5", {7'd0, term_req}, {7'd0, exp_term(k, n, gnt)});
      else if (k > 8 * n + 1 && !gnt)               check("R7", {7'd0, term_req}, {7'd0, exp_term(k, n, gnt)});
      else                                          check("R4", {7'd0, term_req}, {7'd0, exp_term(k, n, gnt)});
    end
    cfg_we = 1'b0;
    frame_on = 1'b0; gnt = 1'b0;
    tick();
    check("R8", {7'd0, term_req}, 8'd0);
    tick();
    check("R8", {7'd0, term_req}, 8'd0);
    if (midwrite) check("R10", cfg_rdata, exp_rdata(newval));
  endtask

  initial begin
    void'($urandom(32'h5EED_0B17));
    rst = 1'b1; cfg_we = 1'b0; cfg_wdata = 8'h00;
    start = 1'b0; frame_on = 1'b0; gnt = 1'b0;
    repeat (3) tick();
    check("R1", cfg_rdata, 8'h00);
    check("R1", {7'd0, term_req}, 8'd0);
    rst = 1'b0;
    tick();
    write_cfg(8'hFF, "R3");
    write_cfg(8'h07, "R3");
    // frame with no start must not terminate
    frame_on = 1'b1; gnt = 1'b0;
    repeat (3) begin tick(); check("R8", {7'd0, term_req}, 8'd0); end
    frame_on = 1'b0;
    tick();
    burst(0, 3, 0, 0);
    burst(1, 4, 0, 0);
    burst(31, 6, 0, 0);
    burst(5, 6, 1, 0);
    burst(0, 6, 1, 0);
    burst(3, 5, 3, 0);
    burst(4, 5, 0, 1);
    burst(2, 30, 0, 0);
    for (int t = 0; t < 30; t++) begin
      burst(int'($urandom_range(0, 31)), int'($urandom_range(0, 20)),
            int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)));
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule